// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the sending half of an asynchronous serial port. Software writes one character into a holding register. As soon as the shifter is free, the block moves that character into its internal shift register and frames it on the serial line. The frame is a low start bit, then the data bits, then a high stop bit. Each bit lasts until the next pulse on the bit-rate tick input. The line rests high between frames.

Software can write the next character while the current one is still on the line. This gives unbroken back-to-back frames. A full flag tells software when the holding register is occupied. A write that arrives while the flag is set is dropped, and it leaves a sticky error bit behind. Characters are 8 or 7 bits long and are sent least- or most-significant bit first. The line output register is clocked on the falling clock edge.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `buf_full` is 0, `buf_q` is 8'hFF, `tx_done` is 0 and `wr_err` is 0.
- R2: A write (`wr_en`) while `buf_full` is 0 and both `pwr_on` and `tx_en` are 1 stores `wr_data` in `buf_q` and sets `buf_full` at that edge. If the shifter is idle, the next edge moves the character into the shifter, clears `buf_full` and begins the start bit.
- R3: A frame is one start bit at 0, then the data bits, then one stop bit at 1. Every bit ends at a clock edge where `bit_tick` is 1. Between frames, `txd` stays at 1.
- R4: With `char7`=0, all 8 buffer bits are sent. With `msb_first`=0 the order is bit 0 up to bit 7. With `msb_first`=1 the order is bit 7 down to bit 0.
- R5: With `char7`=1, 7 bits are sent. With `msb_first`=0 these are bits 0 to 6, and bit 7 is never sent. With `msb_first`=1 these are bits 7 down to 1, and bit 0 is never sent.
- R6: If `buf_full` is 1 at the edge that ends a stop bit, the handoff to the shifter happens at that same edge. The next start bit follows with no idle bit between the frames, and `buf_full` clears.
- R7: `tx_done` is a one-cycle pulse. It appears in the cycle right after the edge that ends each stop bit.
- R8: A write while `buf_full` is 1 leaves `buf_q` and the frame in progress unchanged. It sets `wr_err`, which stays at 1 until reset.
- R9: While `pwr_on` or `tx_en` is 0, the block behaves as follows:
  - `buf_full` is 0 and the line is idle high.
  - No frame starts.
  - A write still updates `buf_q`.
- R10: `txd` changes only on falling clock edges. It goes low half a cycle after the rising edge of the handoff.
- R11: `buf_q` always shows the character last accepted into the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Block power enable |
| tx_en | input | 1 | Transmit enable |
| char7 | input | 1 | 1 selects 7-bit characters, 0 selects 8-bit |
| msb_first | input | 1 | 1 sends the most significant bit first |
| bit_tick | input | 1 | Bit-rate pulse; each bit ends at an edge where it is 1 |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| buf_q | output | 8 | Contents of the holding register |
| txd | output | 1 | Serial line |
| tx_done | output | 1 | End-of-frame pulse |
| buf_full | output | 1 | Holding register occupied |
| wr_err | output | 1 | Sticky flag for a write that was dropped |

## Verification
The assertions assume the following about the inputs:
- Every input is synchronous to the rising clock edge.
- Reset is asserted before the first edge.

No assertion depends on the spacing of `bit_tick` pulses, because a frame is always at least nine edges long. The bench drives every input 1 ns after a rising edge and raises `bit_tick` on every fourth cycle. Its line model samples `txd` 1 ns before each ticked edge, and so it sees only values that were settled at the falling edge.

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on,
  input  logic       tx_en,
  input  logic       char7,
  input  logic       msb_first,
  input  logic       bit_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] buf_q,
  output logic       txd,
  output logic       tx_done,
  output logic       buf_full,
  output logic       wr_err
);
  localparam logic [7:0] BUF_RST   = 8'hFF;
  localparam logic [3:0] STOP_CH8  = 4'd9;
  localparam logic [3:0] STOP_CH7  = 4'd8;

  logic [7:0] sh;
  logic [3:0] ph;
  logic       busy, f7, fm;

  wire       run      = pwr_on & tx_en;
  wire [3:0] stop_ph  = f7 ? STOP_CH7 : STOP_CH8;
  wire       at_stop  = busy && (ph == stop_ph);
  wire       stop_end = at_stop && bit_tick;
  wire       wr_ok    = wr_en && !buf_full;
  wire       load     = run && buf_full && (!busy || stop_end);

  wire line_c = !busy     ? 1'b1 :
                (ph == 0) ? 1'b0 :
                at_stop   ? 1'b1 :
                fm        ? sh[7] : sh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     buf_q <= BUF_RST;
    else if (wr_ok) buf_q <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     buf_full <= 1'b0;
    else if (!run)  buf_full <= 1'b0;
    else if (wr_ok) buf_full <= 1'b1;
    else if (load)  buf_full <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 wr_err <= 1'b0;
    else if (wr_en && buf_full) wr_err <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
      sh   <= '0;
      f7   <= 1'b0;
      fm   <= 1'b0;
    end else if (!run) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (load) begin
      busy <= 1'b1;
      ph   <= '0;
      sh   <= buf_q;
      f7   <= char7;
      fm   <= msb_first;
    end else if (busy && bit_tick) begin
      if (at_stop) begin
        busy <= 1'b0;
        ph   <= '0;
      end else begin
        ph <= ph + 4'd1;
        if (ph != 0) sh <= fm ? {sh[6:0], 1'b0} : {1'b0, sh[7:1]};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_done <= 1'b0;
    else        tx_done <= run && stop_end;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) txd <= 1'b1;
    else        txd <= line_c;
endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on,
  input logic       tx_en,
  input logic       bit_tick,
  input logic       wr_en,
  input logic [7:0] buf_q,
  input logic       txd,
  input logic       tx_done,
  input logic       buf_full,
  input logic       wr_err
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) tx_done |=> !tx_done); // R7
  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> $past(bit_tick)); // R7
  AST_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !buf_full && pwr_on && tx_en) |=> buf_full); // R2
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && buf_full) |=> $stable(buf_q)); // R8
  AST_ERR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && buf_full) |=> wr_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) wr_err |=> wr_err); // R8
  AST_OFF_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n) !(pwr_on && tx_en) |=> !buf_full); // R9
  AST_OFF_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !(pwr_on && tx_en) |-> ##2 txd); // R9
endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tx_en(tx_en), .bit_tick(bit_tick),
  .wr_en(wr_en), .buf_q(buf_q), .txd(txd), .tx_done(tx_done),
  .buf_full(buf_full), .wr_err(wr_err)
);

// File: tb/ser_tx_dbuf_tb_top.sv
`timescale 1ns/1ps
module ser_tx_dbuf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_on = 1'b1, tx_en = 1'b1, char7 = 1'b0, msb_first = 1'b0;
  logic bit_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] buf_q;
  logic txd, tx_done, buf_full, wr_err;

  ser_tx_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tx_en(tx_en), .char7(char7),
    .msb_first(msb_first), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
    .buf_q(buf_q), .txd(txd), .tx_done(tx_done), .buf_full(buf_full), .wr_err(wr_err)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, tcnt = 0;
  int rx_bits = 8;
  logic rx_msb = 1'b0;
  logic rx_on = 1'b0;
  int rx_idx = 0, rx_n = 0, rx_ferr = 0, idle_ticks = 0, rx_end_cyc = -10, n_done = 0;
  logic [7:0] rx_acc = '0;
  logic [7:0] rx_data [0:7];
  int rx_gap [0:7];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #1 bit_tick = (tcnt == 3);
    tcnt = (tcnt + 1) % 4;
  end

  always begin
    @(posedge clk);
    cyc++;
    #9;
    if (tx_done) begin
      n_done++;
      chk("R7 done follows stop end", cyc, rx_end_cyc + 1);
    end
    if (bit_tick) begin
      if (!rx_on) begin
        if (txd === 1'b0) begin
          rx_on = 1'b1; rx_idx = 0; rx_acc = '0;
          if (rx_n < 8) rx_gap[rx_n] = idle_ticks;
        end else idle_ticks++;
      end else if (rx_idx < rx_bits) begin
        rx_acc[rx_msb ? 7 - rx_idx : rx_idx] = txd;
        rx_idx++;
      end else begin
        if (txd !== 1'b1) rx_ferr++;
        if (rx_n < 8) rx_data[rx_n] = rx_acc;
        rx_n++;
        rx_on = 1'b0;
        idle_ticks = 0;
        rx_end_cyc = cyc;
      end
    end
  end

  task automatic rx_clear(input int bits, input logic msb);
    rx_bits = bits; rx_msb = msb; rx_n = 0; rx_ferr = 0; n_done = 0; idle_ticks = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic wait_done(input int cnt);
    for (int i = 0; i < 400 && n_done < cnt; i++) @(posedge clk);
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 txd", txd, 1);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 buf_q", buf_q, 8'hFF);
    chk("R1 tx_done", tx_done, 0);
    chk("R1 wr_err", wr_err, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_single(input logic [7:0] d, input logic c7, input logic msb, input logic [7:0] exp, input string req);
    char7 = c7; msb_first = msb;
    rx_clear(c7 ? 7 : 8, msb);
    wr(d);
    chk("R2 full after write", buf_full, 1);
    chk("R11 buffer readback", buf_q, d);
    @(posedge clk); #1;
    chk("R2 handoff clears full", buf_full, 0);
    chk("R10 txd holds until falling edge", txd, 1);
    #5;
    chk("R10 start bit after falling edge", txd, 0);
    wait_done(1);
    chk({req, " frame count"}, rx_n, 1);
    chk({req, " data"}, rx_data[0], exp);
    chk("R3 stop bit high", rx_ferr, 0);
    chk("R7 one pulse", n_done, 1);
    chk("R3 idle high", txd, 1);
  endtask

  task automatic t_continuous;
    char7 = 1'b0; msb_first = 1'b0;
    rx_clear(8, 1'b0);
    wr(8'h5A);
    @(posedge clk); #1;
    wr(8'hC3);
    chk("R2 second write fills buffer", buf_full, 1);
    wr(8'h0F);
    chk("R8 error set", wr_err, 1);
    chk("R8 buffer kept", buf_q, 8'hC3);
    wait_done(2);
    chk("R6 two frames", rx_n, 2);
    chk("R6 first data", rx_data[0], 8'h5A);
    chk("R6 second data", rx_data[1], 8'hC3);
    chk("R6 no idle between frames", rx_gap[1], 0);
    chk("R6 full cleared", buf_full, 0);
    chk("R7 two pulses", n_done, 2);
    chk("R8 error sticky", wr_err, 1);
  endtask

  task automatic t_disabled;
    tx_en = 1'b0;
    rx_clear(8, 1'b0);
    wr(8'h3C);
    chk("R9 write stored", buf_q, 8'h3C);
    chk("R9 no full flag", buf_full, 0);
    repeat (60) @(posedge clk); #1;
    chk("R9 no frame", rx_n, 0);
    chk("R9 line high", txd, 1);
    tx_en = 1'b1;
    repeat (60) @(posedge clk); #1;
    chk("R9 no frame after enable", rx_n, 0);
    chk("R9 no pulse", n_done, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset();
    t_single(8'hA5, 1'b0, 1'b0, 8'hA5, "R4 lsb8");
    t_single(8'h3B, 1'b0, 1'b1, 8'h3B, "R4 msb8");
    t_single(8'hD5, 1'b1, 1'b0, 8'h55, "R5 lsb7");
    t_single(8'hAB, 1'b1, 1'b1, 8'hAA, "R5 msb7");
    t_continuous();
    t_disabled();
    t_reset();
    summary();
  end
endmodule